// File: doc/BRIEF.md
# Counted Modulo-Loop Branch Controller

This block resolves the branch at the bottom of a counted, software-pipelined loop. It holds two chained counters: a trip counter for the source iterations still to start, and a drain counter for the stages still to finish. It also holds a rotating base and a file of 64 predicate bits. Predicates 16 to 63 form a rotating window, and predicates 0 to 15 stay fixed. Each accepted branch strobe does four things. It decides whether the loop continues. It writes a stage-enable bit into logical predicate 63. It rotates the window by decrementing the base modulo 48, so that the bit just written reads back as logical predicate 16. Finally, it decrements whichever counter the current phase calls for. The pipeline therefore fills, runs and drains under hardware control.

Software first loads both counters and initialises the predicate file in one write. The bulk write addresses physical predicates and ignores the rotating base. Software then issues one strobe per kernel pass and reads the registered taken flag one cycle later. A combinational read port returns any predicate by its logical index, with the current rotation applied.

Top module: `loop_branch_ctrl`

## Requirements
- R1: After reset, both counters and the rotating base are zero and `takenValid` is low. Every predicate reads 0 except predicate 0, which always reads 1.
- R2: `takenValid` is high for exactly one cycle, in the cycle after an accepted strobe. A strobe is accepted when no load input is active in the same cycle. `taken` is high only while `takenValid` is high.
- R3: A strobe with trip count non-zero is taken. It writes 1 as the stage bit, decrements the trip count and leaves the drain count unchanged.
- R4: A strobe with trip count zero and drain count greater than 1 is taken. It writes 0 as the stage bit and decrements the drain count.
- R5: A strobe with trip count zero and drain count 1 is not taken. It sets the drain count to 0, and it still writes a 0 stage bit and rotates.
- R6: A strobe with both counts zero is not taken. It changes neither the predicates, the rotating base nor the counters.
- R7: Rotation decrements the base modulo 48, so 0 becomes 47. Logical predicate p maps to physical predicate 16 + ((p − 16 + base) mod 48). The stage bit written on a branch reads as logical 16 after it, and the bit at logical p (16 ≤ p < 63) moves to logical p+1.
- R8: The bulk initialisation writes bit i of `predInitVal` into physical predicate i for i from 1 to 63, regardless of the current base. Bit 0 is ignored.
- R9: A trip-count load, drain-count load or bulk initialisation in the same cycle as a strobe wins. The load takes effect and the strobe is dropped: no `takenValid`, no rotation and no counter change.
- R10: Predicates 0 to 15 never move under rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brStrobe | input | 1 | Loop branch executes this cycle |
| lcLoad | input | 1 | Load the trip counter |
| lcLoadVal | input | LC_W | New trip count |
| ecLoad | input | 1 | Load the drain counter |
| ecLoadVal | input | EC_W | New drain count |
| predInit | input | 1 | Bulk physical predicate write |
| predInitVal | input | NUM_PRED | Physical predicate image; bit 0 ignored |
| predRdIdx | input | IDX_W | Logical predicate index to read |
| predRdVal | output | 1 | Value of the logical predicate selected |
| takenValid | output | 1 | Branch result valid (cycle after strobe) |
| taken | output | 1 | Branch taken |

## Verification
The hardest state to reach from the ports is a rotating base that has wrapped past zero while the predicates still hold a known image. That state shows whether the logical-to-physical mapping and the base-ignoring bulk write agree. A long loop with a trip count of 50 and a drain count of 2 drives the base through more than one full wrap. A bulk write follows at that odd base, and every logical rotating index is then read back against a model of the physical file. The case of both counts at zero sits next to the drain-to-one exit. It is reached by strobing again after a completed loop, and the predicates are re-read to confirm that nothing moved.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef struct packed {
    logic rotate;
    logic decLc;
    logic decEc;
    logic stageBit;
  } lbcStrobes_t;
endpackage

// File: rtl/lbc_control.sv
module lbc_control
  import lbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        brStrobe,
  input  logic        anyLoad,
  input  logic        lcZero,
  input  logic        ecZero,
  input  logic        ecOne,
  output lbcStrobes_t strb,
  output logic        accept,
  output logic        takenQ,
  output logic        takenValidQ
);
  logic takeNow;

  always_comb begin
    accept        = brStrobe & ~anyLoad;
    strb.decLc    = accept & ~lcZero;
    strb.decEc    = accept & lcZero & ~ecZero;
    strb.rotate   = accept & (~lcZero | ~ecZero);
    strb.stageBit = ~lcZero;
    // continue while iterations remain or more than one drain stage remains
    takeNow       = accept & (~lcZero | (~ecZero & ~ecOne));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takenQ      <= 1'b0;
      takenValidQ <= 1'b0;
    end else begin
      takenQ      <= takeNow;
      takenValidQ <= accept;
    end
  end
endmodule

// File: rtl/lbc_datapath.sv
module lbc_datapath
  import lbc_pkg::*;
#(
  parameter int LC_W     = 16,
  parameter int EC_W     = 6,
  parameter int NUM_PRED = 64,
  parameter int ROT_BASE = 16,
  localparam int ROT_CNT = NUM_PRED - ROT_BASE,
  localparam int IDX_W   = $clog2(NUM_PRED),
  localparam int RRB_W   = $clog2(ROT_CNT),
  localparam int SB_W    = $clog2(ROT_BASE)
)(
  input  logic                clk,
  input  logic                rstN,
  input  lbcStrobes_t         strb,
  input  logic                lcLoad,
  input  logic [LC_W-1:0]     lcLoadVal,
  input  logic                ecLoad,
  input  logic [EC_W-1:0]     ecLoadVal,
  input  logic                predInit,
  input  logic [NUM_PRED-1:0] predInitVal,
  input  logic [IDX_W-1:0]    predRdIdx,
  output logic                predRdVal,
  output logic                lcZero,
  output logic                ecZero,
  output logic                ecOne,
  output logic [LC_W-1:0]     lcCur,
  output logic [EC_W-1:0]     ecCur,
  output logic [RRB_W-1:0]    rrbCur
);
  typedef logic [IDX_W:0] sum_t;

  logic [LC_W-1:0]     lcQ;
  logic [EC_W-1:0]     ecQ;
  logic [RRB_W-1:0]    rrbQ, rrbNext;
  logic [ROT_CNT-1:0]  rotPredQ;
  logic [ROT_BASE-1:0] fixPredQ;
  logic [RRB_W-1:0]    wrOff, rdOff;
  logic [IDX_W-1:0]    rdRel;

  // logical offset within the window -> physical offset, given the base
  function automatic logic [RRB_W-1:0] physOff(input logic [IDX_W-1:0] off,
                                               input logic [RRB_W-1:0] base);
    sum_t s;
    s = sum_t'(off) + sum_t'(base);
    if (s >= sum_t'(ROT_CNT)) s = s - sum_t'(ROT_CNT);
    return s[RRB_W-1:0];
  endfunction

  always_comb begin
    rrbNext = (rrbQ == '0) ? RRB_W'(ROT_CNT - 1) : rrbQ - 1'b1;
    wrOff   = physOff(IDX_W'(ROT_CNT - 1), rrbQ);
    rdRel   = predRdIdx - IDX_W'(ROT_BASE);
    rdOff   = physOff(rdRel, rrbQ);
    if (predRdIdx < IDX_W'(ROT_BASE)) predRdVal = fixPredQ[predRdIdx[SB_W-1:0]];
    else                              predRdVal = rotPredQ[rdOff];
    lcZero = (lcQ == '0);
    ecZero = (ecQ == '0);
    ecOne  = (ecQ == EC_W'(1));
    lcCur  = lcQ;
    ecCur  = ecQ;
    rrbCur = rrbQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lcQ      <= '0;
      ecQ      <= '0;
      rrbQ     <= '0;
      rotPredQ <= '0;
      fixPredQ <= ROT_BASE'(1);
    end else begin
      if (lcLoad)          lcQ <= lcLoadVal;
      else if (strb.decLc) lcQ <= lcQ - 1'b1;

      if (ecLoad)          ecQ <= ecLoadVal;
      else if (strb.decEc) ecQ <= ecQ - 1'b1;

      if (predInit) begin
        rotPredQ <= predInitVal[NUM_PRED-1:ROT_BASE];
        fixPredQ <= {predInitVal[ROT_BASE-1:1], 1'b1};
      end else if (strb.rotate) begin
        rotPredQ[wrOff] <= strb.stageBit;
      end

      if (strb.rotate) rrbQ <= rrbNext;
    end
  end
endmodule

// File: rtl/loop_branch_ctrl.sv
module loop_branch_ctrl
  import lbc_pkg::*;
#(
  parameter int LC_W     = 16,
  parameter int EC_W     = 6,
  parameter int NUM_PRED = 64,
  parameter int ROT_BASE = 16,
  localparam int ROT_CNT = NUM_PRED - ROT_BASE,
  localparam int IDX_W   = $clog2(NUM_PRED),
  localparam int RRB_W   = $clog2(ROT_CNT)
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                brStrobe,
  input  logic                lcLoad,
  input  logic [LC_W-1:0]     lcLoadVal,
  input  logic                ecLoad,
  input  logic [EC_W-1:0]     ecLoadVal,
  input  logic                predInit,
  input  logic [NUM_PRED-1:0] predInitVal,
  input  logic [IDX_W-1:0]    predRdIdx,
  output logic                predRdVal,
  output logic                takenValid,
  output logic                taken
);
  lbcStrobes_t     strb;
  logic            accept, lcZero, ecZero, ecOne;
  logic [LC_W-1:0] lcCur;
  logic [EC_W-1:0] ecCur;
  logic [RRB_W-1:0] rrbCur;

  lbc_control u_ctrl (
    .clk, .rstN, .brStrobe,
    .anyLoad(lcLoad | ecLoad | predInit),
    .lcZero, .ecZero, .ecOne, .strb, .accept,
    .takenQ(taken), .takenValidQ(takenValid)
  );

  lbc_datapath #(.LC_W(LC_W), .EC_W(EC_W), .NUM_PRED(NUM_PRED), .ROT_BASE(ROT_BASE)) u_dp (
    .clk, .rstN, .strb, .lcLoad, .lcLoadVal, .ecLoad, .ecLoadVal,
    .predInit, .predInitVal, .predRdIdx, .predRdVal,
    .lcZero, .ecZero, .ecOne, .lcCur, .ecCur, .rrbCur
  );
endmodule

// File: rtl/lbc_checker.sv
module lbc_checker #(
  parameter int LC_W  = 16,
  parameter int EC_W  = 6,
  parameter int RRB_W = 6,
  parameter int ROT_CNT = 48
)(
  input logic             clk,
  input logic             rstN,
  input logic             brStrobe,
  input logic             lcLoad,
  input logic [LC_W-1:0]  lcLoadVal,
  input logic             ecLoad,
  input logic             predInit,
  input logic             takenValid,
  input logic             taken,
  input logic [LC_W-1:0]  lcCur,
  input logic [EC_W-1:0]  ecCur,
  input logic [RRB_W-1:0] rrbCur
);
  logic acc;
  assign acc = brStrobe & ~lcLoad & ~ecLoad & ~predInit;

  assert_valid_after_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    takenValid |-> $past(acc));
  assert_taken_qualified_R2: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> takenValid);
  assert_kernel_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (acc && lcCur != '0) |=> (taken && lcCur == $past(lcCur) - 1'b1 && ecCur == $past(ecCur)));
  assert_epilog_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (acc && lcCur == '0 && ecCur > EC_W'(1)) |=> (taken && ecCur == $past(ecCur) - 1'b1));
  assert_drain_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (acc && lcCur == '0 && ecCur == EC_W'(1)) |=> (!taken && takenValid && ecCur == '0 && rrbCur != $past(rrbCur)));
  assert_idle_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (acc && lcCur == '0 && ecCur == '0) |=> (!taken && $stable(rrbCur) && ecCur == '0 && lcCur == '0));
  assert_base_in_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    rrbCur < RRB_W'(ROT_CNT));
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lcLoad && brStrobe) |=> (lcCur == $past(lcLoadVal) && !takenValid && $stable(rrbCur)));
endmodule

bind loop_branch_ctrl lbc_checker #(.LC_W(LC_W), .EC_W(EC_W), .RRB_W(RRB_W), .ROT_CNT(ROT_CNT)) u_chk (
  .clk(clk), .rstN(rstN), .brStrobe(brStrobe), .lcLoad(lcLoad), .lcLoadVal(lcLoadVal),
  .ecLoad(ecLoad), .predInit(predInit), .takenValid(takenValid), .taken(taken),
  .lcCur(lcCur), .ecCur(ecCur), .rrbCur(rrbCur)
);

// File: tb/sim_loop_branch_ctrl.sv
module sim_loop_branch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LC_W = 16;
  localparam int EC_W = 6;
  localparam int NP = 64;
  localparam int RB = 16;
  localparam int RC = NP - RB;
  localparam int NVEC = 6;
  localparam int VEC_LC[NVEC]    = '{3, 0, 5, 2, 0, 50};
  localparam int VEC_EC[NVEC]    = '{3, 4, 1, 0, 1, 2};
  localparam int VEC_TAKEN[NVEC] = '{5, 3, 5, 2, 0, 51};

  logic clk = 0, rstN = 0;
  logic brStrobe = 0, lcLoad = 0, ecLoad = 0, predInit = 0;
  logic [LC_W-1:0] lcLoadVal = '0;
  logic [EC_W-1:0] ecLoadVal = '0;
  logic [NP-1:0] predInitVal = '0;
  logic [5:0] predRdIdx = '0;
  logic predRdVal, takenValid, taken;

  int checks = 0, errors = 0;
  int mLc = 0, mEc = 0, mRrb = 0;
  bit mPhys[NP];
  bit doneFlag = 0;

  loop_branch_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int logToPhys(input int p);
    if (p < RB) return p;
    return RB + ((p - RB + mRrb) % RC);
  endfunction

  function automatic bit modelRead(input int p);
    return mPhys[logToPhys(p)];
  endfunction

  // requirement-level model of one accepted strobe; returns expected taken
  function automatic bit modelBranch();
    bit tk;
    if (mLc != 0) begin
      mPhys[logToPhys(63)] = 1; mLc--; tk = 1;
      mRrb = (mRrb == 0) ? RC - 1 : mRrb - 1;
    end else if (mEc > 1) begin
      mPhys[logToPhys(63)] = 0; mEc--; tk = 1;
      mRrb = (mRrb == 0) ? RC - 1 : mRrb - 1;
    end else if (mEc == 1) begin
      mPhys[logToPhys(63)] = 0; mEc = 0; tk = 0;
      mRrb = (mRrb == 0) ? RC - 1 : mRrb - 1;
    end else tk = 0;
    return tk;
  endfunction

  task automatic readPred(input int p, output bit v);
    predRdIdx = 6'(p);
    #1;
    v = predRdVal;
  endtask

  task automatic loadCounts(input int lc, input int ec);
    @(negedge clk);
    lcLoad = 1; lcLoadVal = LC_W'(lc);
    ecLoad = 1; ecLoadVal = EC_W'(ec);
    @(negedge clk);
    lcLoad = 0; ecLoad = 0;
    mLc = lc; mEc = ec;
  endtask

  task automatic doBranch(input string req, output bit tk);
    bit expTk;
    @(negedge clk);
    brStrobe = 1;
    @(negedge clk);
    brStrobe = 0;
    expTk = modelBranch();
    chk(takenValid === 1'b1, {req, " valid"}, int'(takenValid), 1);
    chk(taken === expTk, {req, " taken"}, int'(taken), int'(expTk));
    tk = taken;
    @(negedge clk);
    chk(takenValid === 1'b0, "R2 valid one cycle", int'(takenValid), 0);
  endtask

  task automatic checkAllPreds(input string req);
    bit v;
    for (int p = 0; p < NP; p++) begin
      readPred(p, v);
      chk(v === modelRead(p), req, int'(v), int'(modelRead(p)));
    end
  endtask

  initial begin
    bit v, tk;
    int cnt;
    for (int i = 0; i < NP; i++) mPhys[i] = 0;
    mPhys[0] = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk(takenValid === 1'b0, "R1 takenValid", int'(takenValid), 0);
    checkAllPreds("R1 reset predicates");

    // R6 idle strobe at reset: not taken, nothing moves
    doBranch("R6", tk);
    checkAllPreds("R6 no rotation");

    // vector walk: R3 R4 R5 R7
    for (int k = 0; k < NVEC; k++) begin
      loadCounts(VEC_LC[k], VEC_EC[k]);
      cnt = 0;
      for (int g = 0; g < 200; g++) begin
        doBranch("R3/R4/R5", tk);
        readPred(16, v);
        chk(v === modelRead(16), "R7 stage bit at p16", int'(v), int'(modelRead(16)));
        readPred(40, v);
        chk(v === modelRead(40), "R7 window p40", int'(v), int'(modelRead(40)));
        readPred(7, v);
        chk(v === modelRead(7), "R10 fixed p7", int'(v), int'(modelRead(7)));
        if (!tk) break;
        cnt++;
      end
      chk(cnt == VEC_TAKEN[k], "R3 R4 R5 taken count", cnt, VEC_TAKEN[k]);
    end

    // R6 after a drained loop: strobe again, nothing moves
    doBranch("R6 second exit", tk);
    checkAllPreds("R6 frozen");

    // R8 bulk write at a non-zero base, then R7 mapping of every index
    chk(mRrb != 0, "R7 base wrapped to nonzero", mRrb, 1);
    @(negedge clk);
    predInit = 1;
    predInitVal = 64'hA5C3_0F96_7E11_D2B4;
    @(negedge clk);
    predInit = 0;
    for (int i = 1; i < NP; i++) mPhys[i] = predInitVal[i];
    mPhys[0] = 1;
    checkAllPreds("R8 physical init with R7 mapping");

    // R7 one kernel step shifts logical p -> p+1
    loadCounts(1, 1);
    doBranch("R3", tk);
    checkAllPreds("R7 shift after branch");
    readPred(0, v);
    chk(v === 1'b1, "R8 p0 always 1", int'(v), 1);

    // R9 load in same cycle as strobe: strobe dropped
    @(negedge clk);
    brStrobe = 1; lcLoad = 1; lcLoadVal = 16'd4;
    @(negedge clk);
    brStrobe = 0; lcLoad = 0; mLc = 4;
    chk(takenValid === 1'b0, "R9 lc load drops strobe", int'(takenValid), 0);
    checkAllPreds("R9 no rotation on lc load");
    @(negedge clk);
    brStrobe = 1; predInit = 1; predInitVal = '0;
    @(negedge clk);
    brStrobe = 0; predInit = 0;
    for (int i = 1; i < NP; i++) mPhys[i] = 0;
    chk(takenValid === 1'b0, "R9 init drops strobe", int'(takenValid), 0);
    checkAllPreds("R9 init applied");
    // counters kept the loaded value: 4 kernel + 1 drain exit
    cnt = 0;
    for (int g = 0; g < 10; g++) begin
      doBranch("R9 follow-up", tk);
      if (!tk) break;
      cnt++;
    end
    chk(cnt == 4, "R9 loaded trip count used", cnt, 4);

    doneFlag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule